// File: doc/BRIEF.md
# Dual-channel serial interrupt controller

This block collects the interrupt conditions of a two-channel serial controller and drives a single active-low interrupt request. The transmit-ready and receive-ready (or FIFO-full) levels of each channel and a counter-done level enter as plain inputs. Each channel also supplies a break-change event pulse, which is held in a sticky flag until a dedicated clear strobe arrives. Four general input pins are synchronized inside the block and watched for level changes. Each change is recorded per pin until software reads the change-capture register.

Software uses a byte-wide register bus with one address nibble and separate read and write strobes. Reads are combinational from the address. A read strobe at the change-capture address also clears the recorded changes. At one shared offset, a read returns the raw status and a write loads the interrupt mask. A separate read-only offset returns the status ANDed with the mask.

Top module: `duirq_top`

## Requirements
- R1: After reset irq_n is 1, and the mask, vector, pin-enable and every sticky flag are zero.
- R2: The status byte has this layout, bit 7 down to bit 0: pin change, break change B, receive ready B, transmit ready B, counter done, break change A, receive ready A, transmit ready A. The ready and counter bits follow their inputs in the same cycle.
- R3: Offset 0x5 returns the status byte on a read. A write to 0x5 loads the mask, and the mask never appears in the status read.
- R4: Offset 0x2 returns status AND mask.
- R5: Offset 0xC is a read/write vector byte.
- R6: A break-change bit is set by a one-cycle event pulse and holds until its clear input is pulsed. When the event and the clear arrive in the same cycle, the bit is set.
- R7: A level change on an enabled pin sets status bit 7 on the third rising edge after the pin changes, and no earlier.
- R8: Offset 0x4 reads {per-pin change flags [7:4], synchronized pin levels [3:0]}, with bit 4 and bit 0 belonging to pin 0. A read strobe there clears the change flags and status bit 7.
- R9: A pin change detected in the same cycle as a capture read stays pending: its flag and status bit 7 remain set after that read.
- R10: irq_n is 0 exactly when at least one status bit and its mask bit are both 1.
- R11: A write to offset 0x4 loads the pin enables from wdata[3:0], and bits 7:4 are ignored. A change on a disabled pin is still flagged in the capture register but does not set status bit 7.
- R12: A read of any unmapped offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe (clears the capture flags at 0x4) |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| tx_rdy_a | input | 1 | Channel A transmit ready level |
| rx_rdy_a | input | 1 | Channel A receive ready / FIFO full level |
| brk_evt_a | input | 1 | Channel A break-change event pulse |
| brk_clr_a | input | 1 | Channel A break-change flag clear |
| tx_rdy_b | input | 1 | Channel B transmit ready level |
| rx_rdy_b | input | 1 | Channel B receive ready / FIFO full level |
| brk_evt_b | input | 1 | Channel B break-change event pulse |
| brk_clr_b | input | 1 | Channel B break-change flag clear |
| cnt_done | input | 1 | Counter done level |
| pins_in | input | 4 | Monitored input pins (asynchronous) |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach is a pin change that is detected in exactly the cycle in which software reads the capture register. Reaching it needs the synchronizer delay counted edge by edge. The bench changes a pin on a falling edge and lets two rising edges pass, then strobes the capture read across the third edge. It then checks that the new flag and status bit 7 survived that read. The same edge counting is used to show that status bit 7 stays low after two edges and is set after the third.

// File: rtl/duirq_pkg.sv
package duirq_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int NPIN   = 4;
    localparam int NCHAN  = 2;

    localparam logic [ADDR_W-1:0] OFF_MISR = 4'h2;
    localparam logic [ADDR_W-1:0] OFF_PIN  = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_STAT = 4'h5;
    localparam logic [ADDR_W-1:0] OFF_VEC  = 4'hC;

    localparam int B_TXA = 0;
    localparam int B_RXA = 1;
    localparam int B_BKA = 2;
    localparam int B_CNT = 3;
    localparam int B_TXB = 4;
    localparam int B_RXB = 5;
    localparam int B_BKB = 6;
    localparam int B_PIN = 7;
endpackage

// File: rtl/duirq_pin_watch.sv
module duirq_pin_watch #(
    parameter int NPIN        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pins_i,
    input  logic [NPIN-1:0] en_i,
    input  logic            clr_i,
    output logic [NPIN-1:0] level_o,
    output logic [NPIN-1:0] flag_o,
    output logic            pend_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0][NPIN-1:0] sync;
        logic [NPIN-1:0]                  prev;
        logic [NPIN-1:0]                  flag;
        logic                             pend;
    } pw_t;

    pw_t st_d, st_q;
    logic [NPIN-1:0] edge_w;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = pins_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        edge_w       = st_q.sync[SYNC_STAGES-1] ^ st_q.prev;
        st_d.prev    = st_q.sync[SYNC_STAGES-1];
        // a new edge wins over a simultaneous read clear
        st_d.flag    = (st_q.flag & ~{NPIN{clr_i}}) | edge_w;
        st_d.pend    = (st_q.pend & ~clr_i) | (|(edge_w & en_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.sync[SYNC_STAGES-1];
    assign flag_o  = st_q.flag;
    assign pend_o  = st_q.pend;

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((st_q.flag & $past(st_q.flag)) == $past(st_q.flag))); // R8
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && edge_w == '0) |=> (st_q.flag == '0 && !st_q.pend)); // R8
    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (edge_w & en_i) != '0) |=> st_q.pend); // R9
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pend && (edge_w & en_i) == '0 && en_i == '0) |=> !st_q.pend); // R11
endmodule

// File: rtl/duirq_status.sv
module duirq_status
    import duirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCHAN-1:0] tx_rdy_i,
    input  logic [NCHAN-1:0] rx_rdy_i,
    input  logic [NCHAN-1:0] brk_evt_i,
    input  logic [NCHAN-1:0] brk_clr_i,
    input  logic             cnt_done_i,
    input  logic             pin_pend_i,
    output logic [DATA_W-1:0] status_o
);
    typedef struct packed {
        logic [NCHAN-1:0] brk;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCHAN; c++) begin
            st_d.brk[c] = (st_q.brk[c] & ~brk_clr_i[c]) | brk_evt_i[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_o        = '0;
        status_o[B_TXA] = tx_rdy_i[0];
        status_o[B_RXA] = rx_rdy_i[0];
        status_o[B_BKA] = st_q.brk[0];
        status_o[B_CNT] = cnt_done_i;
        status_o[B_TXB] = tx_rdy_i[1];
        status_o[B_RXB] = rx_rdy_i[1];
        status_o[B_BKB] = st_q.brk[1];
        status_o[B_PIN] = pin_pend_i;
    end

    AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt_i[0] |=> status_o[B_BKA]); // R6
    AST_BRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[B_BKB] && !brk_clr_i[1]) |=> status_o[B_BKB]); // R6
    AST_BRK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_clr_i[0] && !brk_evt_i[0]) |=> !status_o[B_BKA]); // R6
endmodule

// File: rtl/duirq_regs.sv
module duirq_regs
    import duirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] capture_i,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] mask_o,
    output logic [NPIN-1:0]   pin_en_o,
    output logic              cap_rd_o
);
    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] vec;
        logic [NPIN-1:0]   pin_en;
    } reg_t;

    reg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (addr)
                OFF_STAT: st_d.mask   = wdata;
                OFF_PIN:  st_d.pin_en = wdata[NPIN-1:0];
                OFF_VEC:  st_d.vec    = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (addr)
            OFF_MISR: rdata = status_i & st_q.mask;
            OFF_PIN:  rdata = capture_i;
            OFF_STAT: rdata = status_i;
            OFF_VEC:  rdata = st_q.vec;
            default:  rdata = '0;
        endcase
    end

    assign mask_o   = st_q.mask;
    assign pin_en_o = st_q.pin_en;
    assign cap_rd_o = rd_en && (addr == OFF_PIN);

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_STAT) |=> (mask_o == $past(wdata))); // R3
    AST_VEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_VEC) |=> (st_q.vec == $past(wdata))); // R5
    AST_PINEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_PIN) |=> (pin_en_o == $past(wdata[NPIN-1:0]))); // R11
    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFF_STAT) |=> $stable(mask_o)); // R3
endmodule

// File: rtl/duirq_top.sv
module duirq_top
    import duirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tx_rdy_a,
    input  logic              rx_rdy_a,
    input  logic              brk_evt_a,
    input  logic              brk_clr_a,
    input  logic              tx_rdy_b,
    input  logic              rx_rdy_b,
    input  logic              brk_evt_b,
    input  logic              brk_clr_b,
    input  logic              cnt_done,
    input  logic [NPIN-1:0]   pins_in,
    output logic              irq_n
);
    logic [NPIN-1:0]   level_w, flag_w, pin_en_w;
    logic              pend_w, cap_rd_w;
    logic [DATA_W-1:0] status_w, mask_w, capture_w;

    duirq_pin_watch #(.NPIN(NPIN), .SYNC_STAGES(2)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  (pins_in),
        .en_i    (pin_en_w),
        .clr_i   (cap_rd_w),
        .level_o (level_w),
        .flag_o  (flag_w),
        .pend_o  (pend_w)
    );

    duirq_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_rdy_i   ({tx_rdy_b, tx_rdy_a}),
        .rx_rdy_i   ({rx_rdy_b, rx_rdy_a}),
        .brk_evt_i  ({brk_evt_b, brk_evt_a}),
        .brk_clr_i  ({brk_clr_b, brk_clr_a}),
        .cnt_done_i (cnt_done),
        .pin_pend_i (pend_w),
        .status_o   (status_w)
    );

    assign capture_w = {flag_w, level_w};

    duirq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .status_i  (status_w),
        .capture_i (capture_w),
        .rdata     (rdata),
        .mask_o    (mask_w),
        .pin_en_o  (pin_en_w),
        .cap_rd_o  (cap_rd_w)
    );

    assign irq_n = ~|(status_w & mask_w);

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w == '0) |-> irq_n); // R10
    AST_PIN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w && mask_w[B_PIN]) |-> !irq_n); // R10
endmodule

// File: tb/tb_duirq_top.sv
`timescale 1ns/1ps
module tb_duirq_top;
    logic       clk = 0, rst_n = 0;
    logic       rd_en = 0, wr_en = 0;
    logic [3:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic tx_rdy_a = 0, rx_rdy_a = 0, brk_evt_a = 0, brk_clr_a = 0;
    logic tx_rdy_b = 0, rx_rdy_b = 0, brk_evt_b = 0, brk_clr_b = 0;
    logic cnt_done = 0;
    logic [3:0] pins_in = 0;
    logic       irq_n;
    int errors = 0, checks = 0;
    logic [7:0] got;

    always #4 clk = ~clk;

    duirq_top dut (.*);

    // {levels rx_b,tx_b,cnt,rx_a,tx_a ; mask ; status ; masked ; irq_n}
    localparam logic [29:0] VEC [8] = '{
        {5'b00001, 8'h01, 8'h01, 8'h01, 1'b0},
        {5'b00010, 8'h01, 8'h02, 8'h00, 1'b1},
        {5'b00100, 8'h08, 8'h08, 8'h08, 1'b0},
        {5'b01000, 8'hEF, 8'h10, 8'h00, 1'b1},
        {5'b10000, 8'h20, 8'h20, 8'h20, 1'b0},
        {5'b11111, 8'h00, 8'h3B, 8'h00, 1'b1},
        {5'b11111, 8'hFF, 8'h3B, 8'h3B, 1'b0},
        {5'b01010, 8'h12, 8'h12, 8'h12, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        addr = a; rd_en = 1;
        #1 d = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(2); rst_n = 1; idle(1);
        // R1 reset state
        check("R1 irq_n", {7'b0, irq_n}, 8'h01);
        rd_reg(4'h5, got); check("R1 status", got, 8'h00);
        rd_reg(4'hC, got); check("R1 vector", got, 8'h00);
        rd_reg(4'h2, got); check("R1 masked", got, 8'h00);
        rd_reg(4'h4, got); check("R1 capture", got, 8'h00);

        // R2 R3 R4 R10 vector walk
        for (int v = 0; v < 8; v++) begin
            {rx_rdy_b, tx_rdy_b, cnt_done, rx_rdy_a, tx_rdy_a} = VEC[v][29:25];
            wr_reg(4'h5, VEC[v][24:17]);
            rd_reg(4'h5, got); check("R2/R3 status", got, VEC[v][16:9]);
            rd_reg(4'h2, got); check("R4 masked", got, VEC[v][8:1]);
            check("R10 irq_n", {7'b0, irq_n}, {7'b0, VEC[v][0]});
        end
        {rx_rdy_b, tx_rdy_b, cnt_done, rx_rdy_a, tx_rdy_a} = '0;

        // R5 vector, R12 unmapped
        wr_reg(4'hC, 8'hA5);
        rd_reg(4'hC, got); check("R5 vector", got, 8'hA5);
        rd_reg(4'h7, got); check("R12 unmapped", got, 8'h00);
        rd_reg(4'hF, got); check("R12 unmapped", got, 8'h00);

        // R6 break flags
        wr_reg(4'h5, 8'h44);
        brk_evt_a = 1; idle(1); brk_evt_a = 0;
        idle(3);
        rd_reg(4'h5, got); check("R6 break A held", got, 8'h04);
        check("R10 irq on break", {7'b0, irq_n}, 8'h00);
        brk_clr_a = 1; idle(1); brk_clr_a = 0;
        rd_reg(4'h5, got); check("R6 break A cleared", got, 8'h00);
        check("R10 irq released", {7'b0, irq_n}, 8'h01);
        brk_evt_b = 1; brk_clr_b = 1; idle(1); brk_evt_b = 0; brk_clr_b = 0;
        rd_reg(4'h5, got); check("R6 set wins", got, 8'h40);
        brk_clr_b = 1; idle(1); brk_clr_b = 0;
        rd_reg(4'h5, got); check("R6 break B cleared", got, 8'h00);

        // R11 enable only pin0, upper bits ignored
        wr_reg(4'h4, 8'hF1);
        wr_reg(4'h5, 8'h80);
        pins_in = 4'b0010; idle(4);
        rd_reg(4'h5, got); check("R11 disabled pin no status", got, 8'h00);
        rd_reg(4'h4, got); check("R11/R8 capture", got, 8'h22);
        rd_reg(4'h4, got); check("R8 flags cleared", got, 8'h02);

        // R7 synchronizer latency
        pins_in = 4'b0011;
        rd_reg(4'h5, got); check("R7 before edge 1", got, 8'h00);
        rd_reg(4'h5, got); check("R7 after edge 1", got, 8'h00);
        rd_reg(4'h5, got); check("R7 after edge 2", got, 8'h00);
        rd_reg(4'h5, got); check("R7 after edge 3", got, 8'h80);
        check("R10 pin irq", {7'b0, irq_n}, 8'h00);
        rd_reg(4'h4, got); check("R8 capture pin0", got, 8'h13);
        rd_reg(4'h5, got); check("R8 status cleared", got, 8'h00);
        check("R8 irq released", {7'b0, irq_n}, 8'h01);

        // R9 change coinciding with capture read
        wr_reg(4'h4, 8'h0F);
        pins_in = 4'b0111;
        idle(2);
        rd_reg(4'h4, got);
        rd_reg(4'h5, got); check("R9 status kept", got, 8'h80);
        rd_reg(4'h4, got); check("R9 flag kept", got, 8'h47);
        rd_reg(4'h5, got); check("R9 cleared after", got, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule